// File: doc/BRIEF.md
# Sync Rate Meter

The sync rate meter measures the repetition rate of a display's vertical and horizontal sync inputs. It uses one shared up counter and alternates between two kinds of measurement. In vertical mode it counts timebase ticks between two successive vertical sync pulses, so the vertical rate is the tick rate divided by the count. In horizontal mode it counts horizontal sync pulses inside a fixed window, so each count is worth a fixed number of hertz. When a result is ready, the unit sets a ready flag, can raise an interrupt, and holds the result until the host reads status. That read restarts the counter and hands over to the other measurement.

The unit also works out the polarity of each sync input. It compares how long the line stays high with how long it stays low, and treats the shorter level as the active pulse. Measurements always key on the leading edge of the active pulse. Two overflow flags report a count that wrapped once or twice. A second wrap ends the measurement, which lets software recognise a vertical rate below the counter's range, or no vertical sync at all.

Default parameters give a 10-bit counter, a tick every 256 clocks (31.25 kHz from 8 MHz) and a horizontal window of 65536 clocks (8.192 ms).

Top module: `syncrate_meter`

## Requirements
- R1: After reset the count is 0. The mode flag is 0 (vertical), and the ready, both overflow, interrupt and both polarity flags are 0.
- R2: In vertical mode the first leading edge of vertical sync after a restart clears the count. The count then advances once per tick (one tick every 2^TICK_LOG2 clocks). The next leading edge ends the measurement, so a steady period of P clocks gives a count of P / 2^TICK_LOG2.
- R3: In horizontal mode the count is the number of horizontal sync leading edges in a window of 2^WIN_LOG2 clocks that starts at the status read. A steady period gives window/period within one, and an absent input gives 0.
- R4: Completing a measurement sets the ready flag. The interrupt output is set at the same moment only if the interrupt enable is 1, and it is never 1 while ready is 0.
- R5: While ready is 1 and no read occurs, the count, the mode and the ready flag hold their values whatever the sync inputs do.
- R6: A status read strobe, in any state, clears ready, interrupt, count and both overflow flags, inverts the mode flag and restarts measurement. The result is visible one clock after the strobe.
- R7: When the count wraps from its maximum to 0 for the first time, the first-overflow flag is set and counting goes on. The second wrap clears that flag, sets the second-overflow flag and sets ready. The two overflow flags are never 1 together.
- R8: A polarity flag is 1 when the last high run of its input was shorter than the last low run (positive pulses), and 0 otherwise.
- R9: Measurements trigger on the leading edge of the active pulse. A vertical input with low-going pulses is therefore measured as exactly as one with high-going pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_in | input | 1 | Horizontal sync level, asynchronous |
| vsync_in | input | 1 | Vertical sync level, asynchronous |
| stat_rd | input | 1 | One-clock status read strobe |
| sync_ien | input | 1 | Interrupt enable for measurement complete |
| freq_cnt | output | CNT_W | Measured count |
| hv_mode | output | 1 | 0 = vertical measurement, 1 = horizontal |
| freq_rdy | output | 1 | Measurement complete |
| ovf_once | output | 1 | Count wrapped once |
| ovf_twice | output | 1 | Count wrapped twice |
| hpol_pos | output | 1 | Horizontal sync pulses are high-going |
| vpol_pos | output | 1 | Vertical sync pulses are high-going |
| sync_irq | output | 1 | Interrupt request |

## Verification
A level change on a sync pin reaches the edge detector after two synchroniser flops. The count moves at the third rising clock edge after the pin change. Ready and interrupt are set in the same clock that records the final edge. A status read shows its effect one clock after the strobe. The bench drives and samples on the falling clock edge and checks read effects at the very next falling edge. Polarity and count results are sampled only after waits that cover several full sync periods, plus the fixed three-clock pipeline, so every result has settled before it is compared.

// File: rtl/syncrate_meter.sv
module syncrate_meter #(
  parameter int CNT_W     = 10,
  parameter int TICK_LOG2 = 8,
  parameter int WIN_LOG2  = 16,
  parameter int RUN_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic             stat_rd,
  input  logic             sync_ien,
  output logic [CNT_W-1:0] freq_cnt,
  output logic             hv_mode,
  output logic             freq_rdy,
  output logic             ovf_once,
  output logic             ovf_twice,
  output logic             hpol_pos,
  output logic             vpol_pos,
  output logic             sync_irq
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  // sync pipes: [0] first flop, [1] synchronised, [2] one clock older
  logic [2:0] hs_p, vs_p;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hs_p <= '0;
      vs_p <= '0;
    end else begin
      hs_p <= {hs_p[1:0], hsync_in};
      vs_p <= {vs_p[1:0], vsync_in};
    end

  logic [1:0] lvl, lvl_d, pol, lead;
  assign lvl   = {vs_p[1], hs_p[1]};
  assign lvl_d = {vs_p[2], hs_p[2]};

  // per channel: run lengths of each level decide the polarity
  for (genvar g = 0; g < 2; g++) begin : g_chan
    logic [RUN_W-1:0] run_q, hi_len, lo_len;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        run_q  <= '0;
        hi_len <= '0;
        lo_len <= '0;
      end else if (lvl[g] != lvl_d[g]) begin
        run_q <= {{(RUN_W-1){1'b0}}, 1'b1};
        if (lvl[g]) lo_len <= run_q;
        else        hi_len <= run_q;
      end else if (run_q != RUN_MAX) begin
        run_q <= run_q + 1'b1;
      end
    assign pol[g]  = hi_len < lo_len;
    assign lead[g] = pol[g] ? (lvl[g] & ~lvl_d[g]) : (~lvl[g] & lvl_d[g]);
  end

  // tick prescaler, free running
  logic [TICK_LOG2-1:0] pre_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  wire tick = &pre_q;

  // measurement state
  logic [CNT_W-1:0]    cnt_q;
  logic [WIN_LOG2-1:0] win_q;
  logic hv_q, rdy_q, irq_q, ovf1_q, ovf2_q, armed_q;

  wire inc  = hv_q ? lead[0] : tick;
  wire wrap = inc && (cnt_q == CNT_MAX);
  wire fin  = hv_q ? (&win_q) : (lead[1] && armed_q);
  wire arm  = !hv_q && lead[1] && !armed_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q   <= '0;
      win_q   <= '0;
      hv_q    <= 1'b0;
      rdy_q   <= 1'b0;
      irq_q   <= 1'b0;
      ovf1_q  <= 1'b0;
      ovf2_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (stat_rd) begin
      cnt_q   <= '0;
      win_q   <= '0;
      hv_q    <= ~hv_q;
      rdy_q   <= 1'b0;
      irq_q   <= 1'b0;
      ovf1_q  <= 1'b0;
      ovf2_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (!rdy_q) begin
      win_q <= win_q + 1'b1;
      if (arm) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
        ovf1_q  <= 1'b0;
      end else begin
        if (inc) cnt_q <= cnt_q + 1'b1;
        if (wrap) begin
          ovf1_q <= ~ovf1_q;
          ovf2_q <= ovf1_q;
        end
        if (fin || (wrap && ovf1_q)) begin
          rdy_q <= 1'b1;
          irq_q <= sync_ien;
        end
      end
    end

  assign freq_cnt  = cnt_q;
  assign hv_mode   = hv_q;
  assign freq_rdy  = rdy_q;
  assign ovf_once  = ovf1_q;
  assign ovf_twice = ovf2_q;
  assign hpol_pos  = pol[0];
  assign vpol_pos  = pol[1];
  assign sync_irq  = irq_q;

endmodule

// File: rtl/syncrate_meter_chk.sv
module syncrate_meter_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stat_rd,
  input logic [CNT_W-1:0] freq_cnt,
  input logic             hv_mode,
  input logic             freq_rdy,
  input logic             ovf_once,
  input logic             ovf_twice,
  input logic             sync_irq
);

  p_ovf_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_once && ovf_twice));

  p_twice_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_twice |-> freq_rdy);

  p_irq_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_irq |-> freq_rdy);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_rdy && !stat_rd) |=> (freq_rdy && $stable(freq_cnt) && $stable(hv_mode)));

  p_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> ((hv_mode != $past(hv_mode)) && !freq_rdy && !sync_irq &&
                 (freq_cnt == '0) && !ovf_once && !ovf_twice));

endmodule

bind syncrate_meter syncrate_meter_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .freq_cnt(freq_cnt),
  .hv_mode(hv_mode), .freq_rdy(freq_rdy), .ovf_once(ovf_once),
  .ovf_twice(ovf_twice), .sync_irq(sync_irq)
);

// File: tb/test_syncrate_meter.sv
module test_syncrate_meter;
  localparam int CW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hsync_in = 1'b1, vsync_in = 1'b0, stat_rd = 1'b0, sync_ien = 1'b0;
  logic [CW-1:0] freq_cnt;
  logic hv_mode, freq_rdy, ovf_once, ovf_twice, hpol_pos, vpol_pos, sync_irq;

  int checks = 0, fails = 0;

  // sync generators: period and width in clocks, active level, enable
  int vper = 64, vwid = 4, hper = 16, hwid = 2;
  bit vact = 1'b1, ven = 1'b0, hact = 1'b0, hen = 1'b0;

  always #2.5 clk = ~clk;

  syncrate_meter #(.CNT_W(CW), .TICK_LOG2(2), .WIN_LOG2(8), .RUN_W(8)) i_syncrate_meter (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .stat_rd(stat_rd), .sync_ien(sync_ien), .freq_cnt(freq_cnt),
    .hv_mode(hv_mode), .freq_rdy(freq_rdy), .ovf_once(ovf_once),
    .ovf_twice(ovf_twice), .hpol_pos(hpol_pos), .vpol_pos(vpol_pos),
    .sync_irq(sync_irq)
  );

  initial forever begin
    if (!ven) begin
      vsync_in = !vact;
      @(negedge clk);
    end else begin
      vsync_in = vact;
      repeat (vwid) @(negedge clk);
      vsync_in = !vact;
      repeat (vper - vwid) @(negedge clk);
    end
  end

  initial forever begin
    if (!hen) begin
      hsync_in = !hact;
      @(negedge clk);
    end else begin
      hsync_in = hact;
      repeat (hwid) @(negedge clk);
      hsync_in = !hact;
      repeat (hper - hwid) @(negedge clk);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_read();
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
  endtask

  task automatic wait_rdy(input int lim);
    int n = 0;
    while (!freq_rdy && n < lim) begin
      @(negedge clk);
      n++;
    end
    check(freq_rdy, "R4", "ready within limit", int'(freq_rdy), 1);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(freq_cnt == 0 && !hv_mode && !freq_rdy, "R1", "count/mode/ready",
          {freq_cnt, hv_mode, freq_rdy}, 0);
    check(!ovf_once && !ovf_twice && !sync_irq && !hpol_pos && !vpol_pos, "R1",
          "flags", {ovf_once, ovf_twice, sync_irq, hpol_pos, vpol_pos}, 0);
  endtask

  task automatic t_polarity();
    vact = 1'b1; vper = 64; vwid = 4; ven = 1'b1;
    hact = 1'b0; hper = 16; hwid = 2; hen = 1'b1;
    repeat (300) @(negedge clk);
    check(vpol_pos == 1'b1, "R8", "vertical high pulses", int'(vpol_pos), 1);
    check(hpol_pos == 1'b0, "R8", "horizontal low pulses", int'(hpol_pos), 0);
  endtask

  task automatic t_vertical_pos();
    pulse_read();
    pulse_read();
    check(hv_mode == 1'b0, "R6", "mode back to vertical", int'(hv_mode), 0);
    sync_ien = 1'b1;
    wait_rdy(400);
    check(freq_cnt == 16, "R2", "vertical count period 64", int'(freq_cnt), 16);
    check(sync_irq == 1'b1, "R4", "irq with enable", int'(sync_irq), 1);
    check(!ovf_once && !ovf_twice, "R7", "no overflow", {ovf_once, ovf_twice}, 0);
  endtask

  task automatic t_hold();
    repeat (150) @(negedge clk);
    check(freq_cnt == 16 && freq_rdy, "R5", "result held", int'(freq_cnt), 16);
    check(hv_mode == 1'b0, "R5", "mode held", int'(hv_mode), 0);
  endtask

  task automatic t_horizontal();
    sync_ien = 1'b0;
    pulse_read();
    check(hv_mode == 1'b1, "R6", "mode to horizontal", int'(hv_mode), 1);
    check(!freq_rdy && !sync_irq && freq_cnt == 0, "R6", "cleared by read",
          {freq_rdy, sync_irq, freq_cnt}, 0);
    wait_rdy(400);
    check(freq_cnt >= 15 && freq_cnt <= 17, "R3", "horizontal edges in window",
          int'(freq_cnt), 16);
    check(sync_irq == 1'b0, "R4", "no irq when disabled", int'(sync_irq), 0);
  endtask

  task automatic t_vertical_neg();
    vact = 1'b0; vper = 96; vwid = 6;
    repeat (400) @(negedge clk);
    check(vpol_pos == 1'b0, "R8", "vertical low pulses", int'(vpol_pos), 0);
    pulse_read();
    check(hv_mode == 1'b0, "R6", "mode to vertical", int'(hv_mode), 0);
    wait_rdy(600);
    check(freq_cnt == 24, "R9", "low-going vertical period 96", int'(freq_cnt), 24);
  endtask

  task automatic t_overflow();
    ven = 1'b0;
    repeat (200) @(negedge clk);
    pulse_read();
    pulse_read();
    repeat (300) @(negedge clk);
    check(ovf_once && !ovf_twice && !freq_rdy, "R7", "first wrap",
          {ovf_once, ovf_twice, freq_rdy}, 3'b100);
    repeat (300) @(negedge clk);
    check(!ovf_once && ovf_twice && freq_rdy, "R7", "second wrap",
          {ovf_once, ovf_twice, freq_rdy}, 3'b011);
    check(freq_cnt == 0, "R7", "count after second wrap", int'(freq_cnt), 0);
  endtask

  task automatic t_no_hsync();
    hen = 1'b0;
    repeat (50) @(negedge clk);
    pulse_read();
    wait_rdy(400);
    check(hv_mode == 1'b1 && freq_cnt == 0, "R3", "absent horizontal input",
          int'(freq_cnt), 0);
  endtask

  task automatic t_mid_read();
    ven = 1'b1;
    pulse_read();
    repeat (20) @(negedge clk);
    pulse_read();
    check(hv_mode == 1'b1 && !freq_rdy && freq_cnt == 0, "R6", "read mid measurement",
          {hv_mode, freq_rdy, freq_cnt}, {1'b1, 1'b0, 6'd0});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=150000 cycles expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_polarity();
    t_vertical_pos();
    t_hold();
    t_horizontal();
    t_vertical_neg();
    t_overflow();
    t_no_hsync();
    t_mid_read();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule